// File: doc/BRIEF.md
# Reset Controller with Cause Recording

This block gathers every restart request of a small processor system and turns them into three reset outputs. One output resets the CPU alone, so a live system restarts without losing its debug setup. One output resets the CPU together with the debug blocks: breakpoint, watchpoint/trace, trace macrocell and interrupt controller. The third output resets the bus access port of the debug port. Each output goes low as soon as one of its sources goes high, with no clock needed. It comes back high on a clock edge, through a two-stage release chain.

Alongside the resets, the block keeps a one-hot record of what caused the last restart. It also keeps a CPU lockup flag, which marks an unrecoverable CPU fault without resetting anything, so a debugger can still examine the halted core. A sequencer handles deep sleep for power management. It holds the core resets from the sleep request through power removal, sleep, wake-up and power reapplication, until the core-supply detector reports good. An emulated variant runs the same sequence but leaves the core supply switched on. A one-bit address read port returns either the cause record or the lockup flag.

Top module: `reset_cause_unit`

## Requirements
- R1: While `aonFault` is high, `sysRstN`, `poRstN` and `dapRstN` are low, the cause record reads 8'h01 (bit 0 = always-on supply fault), the lockup flag reads 0 and the sleep sequencer is idle.
- R2: A new reset event replaces the whole cause record with a single bit: bit 1 for a rising `coreFault`, bit 2 for `pinRstN` falling, bit 3 for a rising `wdogExpire`, bit 4 for a rising `swResetReq`, bit 5 for an accepted wake. Any earlier bit 6 is cleared. The record changes on the first clock edge that sees the event.
- R3: A rising `optByteFail` sets bit 6 and keeps the other cause bits. If it rises in the same cycle as another event, the record becomes that event's bit plus bit 6.
- R4: `cpuLockup` sets the lockup flag (bit 0 at read address 1) and asserts no reset output. The flag is cleared on every clock edge where `sysRstN` is low, and the clear wins over a set.
- R5: When several events fall in the same cycle, only the one of highest priority is recorded. The order is core supply, pin, watchdog, software, wake.
- R6: The pin, watchdog, software and option-byte requests pull `sysRstN` low at once and leave `poRstN` and `dapRstN` high. A reset output goes high again on the second clock edge after its last request is gone.
- R7: `coreFault` pulls all three outputs low. `dapRstN` is pulled low only by the two supply faults, and `poRstN` only by those faults and by the deep-sleep hold.
- R8: After `sleepReq` is seen in idle, `poRstN` and `sysRstN` stay low through entry, sleep and wake until `corePowerGood` is seen high in the wake state. `coreSupplyEn` is low only in the sleep state.
- R9: With `emuSleep` high, the same sequence runs and `coreSupplyEn` stays high throughout.
- R10: A `wakeReq` seen in the sleep state starts the wake phase and records cause 8'h20.
- R11: A cause is recorded only when a source newly asserts. A source already held high when an always-on supply fault ends is not recorded until it drops and rises again.
- R12: `rdData` shows the cause record zero-extended when `rdAddr` is 0, and the lockup flag in bit 0 when `rdAddr` is 1. It follows `rdAddr` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| aonFault | input | 1 | Always-on supply failure, active high, asynchronous |
| coreFault | input | 1 | Core/memory supply failure, active high |
| pinRstN | input | 1 | External reset pin, active low |
| wdogExpire | input | 1 | Watchdog expiry |
| swResetReq | input | 1 | Software reset request from the CPU |
| optByteFail | input | 1 | Option-byte check failure |
| cpuLockup | input | 1 | CPU entered an unrecoverable fault |
| sleepReq | input | 1 | Power management asks for deep sleep |
| wakeReq | input | 1 | Wake-up request while asleep |
| corePowerGood | input | 1 | Core supply detector reports a reliable level |
| emuSleep | input | 1 | Emulated sleep: keep core supply on |
| rdAddr | input | 1 | Read select: 0 cause record, 1 lockup flag |
| rdData | output | 8 | Read data |
| coreSupplyEn | output | 1 | Enable of the core/memory supply |
| poRstN | output | 1 | CPU plus debug components reset, active low |
| sysRstN | output | 1 | CPU-only reset, active low |
| dapRstN | output | 1 | Debug bus access port reset, active low |

## Verification
Two functions can act on the same clock edge. First, an option-byte failure can rise in the same cycle as another reset event, so the record must hold the new event's bit and the sticky bit together. Second, the lockup flag can be set in the same cycle that an asserted CPU reset clears it. The bench raises `optByteFail` together with `coreFault`, and holds `cpuLockup` high across a software reset. A behavioural model then decides which result must win, and the outputs are compared with it on every clock: the record must read 8'h42, and the flag must be clear while the reset is low.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CAUSE_W  = 7;
  localparam int EVT_W    = 5;   // core, pin, wdog, sw, wake
  localparam int EDGE_W   = 5;   // core, pin, wdog, sw, opt
  localparam int AON_BIT  = 0;
  localparam int CORE_BIT = 1;
  localparam int WAKE_BIT = 5;
  localparam int OPT_BIT  = 6;
  localparam int NUM_DOM  = 3;   // 0 dap, 1 po, 2 sys

  typedef enum logic [1:0] {DS_IDLE, DS_ENTER, DS_SLEEP, DS_WAKE} dsState_t;

  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic             optSet;
    logic             lockSet;
    logic             lockClr;
  } strobe_t;

  function automatic logic [EVT_W-1:0] pickFirst(input logic [EVT_W-1:0] v);
    logic [EVT_W-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < EVT_W; i++) begin
      if (v[i] && !found) begin
        r[i] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rstc_release.sv
module rstc_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clrReq,
  output logic rstN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clrReq) begin
    if (clrReq) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstN = chain[STAGES-1];
endmodule

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
(
  input  logic    clk,
  input  logic    aonFault,
  input  logic    coreFault,
  input  logic    pinRstN,
  input  logic    wdogExpire,
  input  logic    swResetReq,
  input  logic    optByteFail,
  input  logic    cpuLockup,
  input  logic    sleepReq,
  input  logic    wakeReq,
  input  logic    corePowerGood,
  input  logic    emuSleep,
  input  logic    sysRstN,
  output strobe_t strb,
  output logic    dsRst,
  output logic    coreSupplyEn
);
  logic [EDGE_W-1:0] srcNow, srcPrev, rise;
  dsState_t dsState, dsNext;
  logic wakeHit;

  assign srcNow = {optByteFail, swResetReq, wdogExpire, ~pinRstN, coreFault};
  assign rise   = srcNow & ~srcPrev;

  always_ff @(posedge clk or posedge aonFault) begin
    if (aonFault) srcPrev <= '1;
    else          srcPrev <= srcNow;
  end

  always_comb begin
    dsNext  = dsState;
    wakeHit = 1'b0;
    unique case (dsState)
      DS_IDLE:  if (sleepReq) dsNext = DS_ENTER;
      DS_ENTER: dsNext = DS_SLEEP;
      DS_SLEEP: if (wakeReq) begin
                  dsNext  = DS_WAKE;
                  wakeHit = 1'b1;
                end
      DS_WAKE:  if (corePowerGood) dsNext = DS_IDLE;
      default:  dsNext = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge aonFault) begin
    if (aonFault) begin
      dsState <= DS_IDLE;
      dsRst   <= 1'b0;
    end else begin
      dsState <= dsNext;
      dsRst   <= (dsNext != DS_IDLE);
    end
  end

  assign coreSupplyEn = emuSleep || (dsState != DS_SLEEP);

  always_comb begin
    strb.evt     = {wakeHit, rise[EDGE_W-2:0]};
    strb.optSet  = rise[EDGE_W-1];
    strb.lockSet = cpuLockup;
    strb.lockClr = ~sysRstN;
  end

  // R8: no release while the core supply is not yet good
  a_r8_wait_good: assert property (@(posedge clk) disable iff (aonFault)
    (dsState == DS_WAKE && !corePowerGood) |=> dsRst);

  // R10: the wake phase is entered only from sleep on a wake request
  a_r10_wake_entry: assert property (@(posedge clk) disable iff (aonFault)
    (dsState == DS_WAKE && $past(dsState) != DS_WAKE) |-> ($past(dsState) == DS_SLEEP && $past(wakeReq)));
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              aonFault,
  input  strobe_t           strb,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [CAUSE_W-1:0] causeQ;
  logic               lockQ;

  always_ff @(posedge clk or posedge aonFault) begin
    if (aonFault)          causeQ <= CAUSE_W'(1) << AON_BIT;
    else if (|strb.evt)    causeQ <= {strb.optSet, pickFirst(strb.evt), 1'b0};
    else if (strb.optSet)  causeQ[OPT_BIT] <= 1'b1;
  end

  always_ff @(posedge clk or posedge aonFault) begin
    if (aonFault)          lockQ <= 1'b0;
    else if (strb.lockClr) lockQ <= 1'b0;
    else if (strb.lockSet) lockQ <= 1'b1;
  end

  assign rdData = rdAddr ? DATA_W'(lockQ) : DATA_W'(causeQ);

  // R2: exactly one main cause bit at any time
  a_r2_onehot: assert property (@(posedge clk) disable iff (aonFault)
    $onehot(causeQ[WAKE_BIT:AON_BIT]));

  // R3: the sticky bit alone keeps the recorded cause
  a_r3_opt_keeps: assert property (@(posedge clk) disable iff (aonFault)
    (strb.optSet && strb.evt == '0) |=> (causeQ[WAKE_BIT:AON_BIT] == $past(causeQ[WAKE_BIT:AON_BIT]) && causeQ[OPT_BIT]));

  // R4: an active CPU reset always clears the lockup flag
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (aonFault)
    strb.lockClr |=> !lockQ);

  // R5: a core supply event outranks every other event
  a_r5_core_first: assert property (@(posedge clk) disable iff (aonFault)
    strb.evt[0] |=> causeQ[CORE_BIT]);
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              aonFault,
  input  logic              coreFault,
  input  logic              pinRstN,
  input  logic              wdogExpire,
  input  logic              swResetReq,
  input  logic              optByteFail,
  input  logic              cpuLockup,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic              corePowerGood,
  input  logic              emuSleep,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              coreSupplyEn,
  output logic              poRstN,
  output logic              sysRstN,
  output logic              dapRstN
);
  strobe_t            strb;
  logic               dsRst;
  logic [NUM_DOM-1:0] domReq, domRstN;
  logic               sysReq;

  assign domReq[0] = aonFault | coreFault;
  assign domReq[1] = domReq[0] | dsRst;
  assign domReq[2] = domReq[1] | ~pinRstN | wdogExpire | swResetReq | optByteFail;
  assign sysReq    = domReq[2];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rstc_release #(.STAGES(SYNC_STAGES)) u_rel (
      .clk    (clk),
      .clrReq (domReq[d]),
      .rstN   (domRstN[d])
    );
  end

  assign dapRstN = domRstN[0];
  assign poRstN  = domRstN[1];
  assign sysRstN = domRstN[2];

  rstc_ctrl u_ctrl (
    .clk           (clk),
    .aonFault      (aonFault),
    .coreFault     (coreFault),
    .pinRstN       (pinRstN),
    .wdogExpire    (wdogExpire),
    .swResetReq    (swResetReq),
    .optByteFail   (optByteFail),
    .cpuLockup     (cpuLockup),
    .sleepReq      (sleepReq),
    .wakeReq       (wakeReq),
    .corePowerGood (corePowerGood),
    .emuSleep      (emuSleep),
    .sysRstN       (sysRstN),
    .strb          (strb),
    .dsRst         (dsRst),
    .coreSupplyEn  (coreSupplyEn)
  );

  rstc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .aonFault (aonFault),
    .strb     (strb),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

  // R7: the debug port reset is never active without the full reset
  a_r7_dap_in_po: assert property (@(posedge clk) disable iff (aonFault)
    !dapRstN |-> !poRstN);

  // R7: the full reset always includes the CPU reset
  a_r7_po_in_sys: assert property (@(posedge clk) disable iff (aonFault)
    !poRstN |-> !sysRstN);

  // R8: the sleep hold keeps the full reset active
  a_r8_hold_po: assert property (@(posedge clk) disable iff (aonFault)
    dsRst |-> !poRstN);

  // R6: release only after the request was already gone one edge earlier
  a_r6_late_release: assert property (@(posedge clk) disable iff (aonFault)
    $rose(sysRstN) |-> (!sysReq && !$past(sysReq)));

  // R4: a lockup alone never drops the CPU reset
  a_r4_lockup_silent: assert property (@(posedge clk) disable iff (aonFault)
    (cpuLockup && $past(sysRstN) && !sysReq) |-> sysRstN);
endmodule

// File: tb/test_reset_cause_unit.sv
`timescale 1ns/1ps
module test_reset_cause_unit;
  logic clk = 1'b0;
  logic aonFault = 1'b1, coreFault = 1'b0, pinRstN = 1'b1, wdogExpire = 1'b0;
  logic swResetReq = 1'b0, optByteFail = 1'b0, cpuLockup = 1'b0, sleepReq = 1'b0;
  logic wakeReq = 1'b0, corePowerGood = 1'b1, emuSleep = 1'b0, rdAddr = 1'b0;
  logic [7:0] rdData;
  logic coreSupplyEn, poRstN, sysRstN, dapRstN;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  reset_cause_unit i_reset_cause_unit (
    .clk(clk), .aonFault(aonFault), .coreFault(coreFault), .pinRstN(pinRstN),
    .wdogExpire(wdogExpire), .swResetReq(swResetReq), .optByteFail(optByteFail),
    .cpuLockup(cpuLockup), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .corePowerGood(corePowerGood), .emuSleep(emuSleep), .rdAddr(rdAddr),
    .rdData(rdData), .coreSupplyEn(coreSupplyEn), .poRstN(poRstN),
    .sysRstN(sysRstN), .dapRstN(dapRstN)
  );

  // behavioural reference state
  logic [6:0] mCause;
  bit         mLock;
  int         mSt;      // 0 idle, 1 entering, 2 asleep, 3 waking
  bit         mDs;
  bit   [4:0] mPrev;
  int         relCnt [3];

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void mReset();
    mCause = 7'h01; mLock = 0; mSt = 0; mDs = 0; mPrev = '1;
    for (int d = 0; d < 3; d++) relCnt[d] = 0;
  endfunction

  function automatic bit [2:0] mReq();
    bit [2:0] r;
    r[0] = aonFault | coreFault;
    r[1] = r[0] | mDs;
    r[2] = r[1] | !pinRstN | wdogExpire | swResetReq | optByteFail;
    return r;
  endfunction

  function automatic bit mOut(input int d);
    bit [2:0] r;
    r = mReq();
    return !r[d] && relCnt[d] >= 2;
  endfunction

  initial mReset();

  always @(posedge clk) begin
    if (aonFault) mReset();
    else begin
      bit sysOld;
      bit [2:0] r;
      bit [4:0] src, rise, evt;
      int nxt;
      sysOld = mOut(2);
      r = mReq();
      src = {optByteFail, swResetReq, wdogExpire, !pinRstN, coreFault};
      rise = src & ~mPrev;
      evt = {(mSt == 2 && wakeReq), rise[3:0]};
      if (evt != 0) begin
        for (int j = 0; j < 5; j++) if (evt[j]) begin mCause = 7'(1 << (j + 1)); break; end
        if (rise[4]) mCause[6] = 1'b1;
      end else if (rise[4]) mCause[6] = 1'b1;
      if (!sysOld) mLock = 0; else if (cpuLockup) mLock = 1;
      mPrev = src;
      nxt = mSt;
      case (mSt)
        0: if (sleepReq) nxt = 1;
        1: nxt = 2;
        2: if (wakeReq) nxt = 3;
        default: if (corePowerGood) nxt = 0;
      endcase
      mSt = nxt;
      mDs = (nxt != 0);
      for (int d = 0; d < 3; d++) relCnt[d] = r[d] ? 0 : (relCnt[d] < 2 ? relCnt[d] + 1 : 2);
    end
  end

  always @(negedge clk) begin
    int expRd;
    if (aonFault) mReset();
    expRd = rdAddr ? int'(mLock) : int'(mCause);
    check("R6 sysRstN", sysRstN, mOut(2));
    check("R7 poRstN", poRstN, mOut(1));
    check("R7 dapRstN", dapRstN, mOut(0));
    check("R8 coreSupplyEn", coreSupplyEn, int'(emuSleep || mSt != 2));
    check("R12 rdData", rdData, expRd);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(3); look();
    check("R1 sys low", sysRstN, 0);
    check("R1 po low", poRstN, 0);
    check("R1 dap low", dapRstN, 0);
    check("R1 cause", rdData, 8'h01);
    tick(1); aonFault = 0;
    tick(3); rdAddr = 1; look();
    check("R1 released", {sysRstN, poRstN, dapRstN}, 3'b111);
    check("R12 lock read", rdData, 0);
    rdAddr = 0;

    // R6 pin reset only hits the CPU reset
    tick(1); pinRstN = 0; look();
    check("R6 pin sys", sysRstN, 0);
    check("R6 pin po", poRstN, 1);
    tick(1); pinRstN = 1; look();
    check("R6 no edge yet", sysRstN, 0);
    tick(1); look();
    check("R6 one edge", sysRstN, 0);
    tick(1); look();
    check("R6 two edges", sysRstN, 1);
    check("R2 pin cause", rdData, 8'h04);

    // R3 sticky option-byte bit
    tick(1); optByteFail = 1; tick(1); optByteFail = 0; tick(3); look();
    check("R3 opt kept", rdData, 8'h44);

    // R2 new event clears all other bits
    tick(1); wdogExpire = 1; tick(1); wdogExpire = 0; tick(3); look();
    check("R2 wdog cause", rdData, 8'h08);

    // R5 simultaneous events
    tick(1); wdogExpire = 1; swResetReq = 1; pinRstN = 0;
    tick(1); wdogExpire = 0; swResetReq = 0; pinRstN = 1; tick(3); look();
    check("R5 pin wins", rdData, 8'h04);
    tick(1); coreFault = 1; optByteFail = 1; look();
    check("R7 core dap", dapRstN, 0);
    tick(1); coreFault = 0; optByteFail = 0; tick(3); look();
    check("R5 core plus opt", rdData, 8'h42);

    // R4 lockup flag
    tick(1); cpuLockup = 1; rdAddr = 1; tick(2); look();
    check("R4 lock set", rdData, 1);
    check("R4 no reset", sysRstN, 1);
    tick(1); swResetReq = 1; tick(1); swResetReq = 0; look();
    check("R4 cleared", rdData, 0);
    tick(5); look();
    check("R4 set again", rdData, 1);
    cpuLockup = 0;
    tick(1); pinRstN = 0; tick(1); pinRstN = 1; tick(4); look();
    check("R4 stays clear", rdData, 0);
    rdAddr = 0;

    // R8 real deep sleep
    tick(1); sleepReq = 1; tick(1); sleepReq = 0; tick(1); corePowerGood = 0; look();
    check("R8 supply off", coreSupplyEn, 0);
    check("R8 po held", poRstN, 0);
    tick(3); wakeReq = 1; tick(1); wakeReq = 0; look();
    check("R8 supply on", coreSupplyEn, 1);
    check("R10 wake cause", rdData, 8'h20);
    tick(3); look();
    check("R8 wait good", poRstN, 0);
    corePowerGood = 1; tick(4); look();
    check("R8 released", {poRstN, sysRstN}, 2'b11);

    // R9 emulated deep sleep
    tick(1); emuSleep = 1; sleepReq = 1; tick(1); sleepReq = 0; tick(2); look();
    check("R9 supply kept", coreSupplyEn, 1);
    check("R9 po held", poRstN, 0);
    wakeReq = 1; tick(1); wakeReq = 0; tick(4); look();
    check("R9 released", poRstN, 1);
    emuSleep = 0;

    // R11 held level is not a new event
    tick(1); wdogExpire = 1; tick(1); aonFault = 1; tick(2); aonFault = 0; tick(4); look();
    check("R11 held ignored", rdData, 8'h01);
    wdogExpire = 0; tick(1); wdogExpire = 1; tick(1); wdogExpire = 0; tick(3); look();
    check("R11 new edge", rdData, 8'h08);

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule